// File: doc/BRIEF.md
# Bus-Stepped Wiper Position Register

This block keeps the volatile wiper position of one digitally controlled potentiometer channel. The position is a 6-bit count. It is decoded into a one-hot select of 64 tap switches: position 00h picks the low-end terminal tap and position 3Fh picks the high-end tap. The resistor array that these selects drive lies outside the block.

The position can change in four ways. On reset it takes the stored value of the channel's default data register. A host write loads a value directly. A copy loads the value of one of the channel's four data registers, which the surrounding logic has already selected. In step mode the position moves up or down by one position per serial-bus clock pulse. A one-cycle arm pulse from the command decoder enables step mode. Step mode then stays on until the block sees a stop condition on the synchronised bus samples. While it is on, each rising edge of SCL moves the position toward the high end if SDA is high at that edge, and toward the low end if SDA is low. The count saturates at both ends.

Both load inputs are valid-only streams with no back-pressure. The block accepts every beat in the cycle its valid is high, so there is no ready signal and the sender never waits. The bus samples and the arm pulse are plain control inputs.

Top module: `wcr_stepper`

## Requirements
- R1: At all times `tap` has exactly one bit set, and that bit is `tap[pos]`. Bit 0 is the low-end terminal and bit 63 is the high-end terminal.
- R2: While `rst_n` is low, each clock edge loads `pos` with `dr0_val` and turns step mode off.
- R3: When `wr_valid` is high at a clock edge, `pos` equals `wr_data` after that edge.
- R4: When `xfr_valid` is high and `wr_valid` is low at a clock edge, `pos` equals `xfr_data` after that edge. If both valids are high, the host write wins.
- R5: In step mode, a clock edge where `scl_s` is 1 and was 0 at the previous edge, with `sda_s` = 1, raises `pos` by one.
- R6: In step mode, the same SCL rising edge with `sda_s` = 0 lowers `pos` by one.
- R7: A step up at 3Fh leaves `pos` at 3Fh, and a step down at 00h leaves it at 00h. The count never wraps.
- R8: When step mode is off, SCL pulses leave `pos` unchanged.
- R9: A one-cycle `step_arm` pulse turns step mode on, and it stays on across any number of steps. A stop condition turns it off: `sda_s` rising while `scl_s` is high at both that edge and the previous one. If arm and stop occur at the same edge, arm wins.
- R10: A load (R3 or R4) at the same edge as a step takes priority. The step is dropped and `pos` takes the load value.
- R11: Holding `scl_s` high for several cycles gives only one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr0_val | input | 6 | Stored default data register value, loaded on reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_data | input | 6 | Host write position |
| xfr_valid | input | 1 | Data register copy beat valid |
| xfr_data | input | 6 | Selected data register value |
| step_arm | input | 1 | One-cycle pulse entering step mode |
| scl_s | input | 1 | Synchronised SCL sample |
| sda_s | input | 1 | Synchronised SDA sample |
| pos | output | 6 | Current wiper position |
| tap | output | 64 | One-hot tap switch select |

## Verification
The assertions check the following on every cycle:
- the tap select is one-hot and matches the position;
- a host write or a copy lands on the next cycle, with the host write taking priority;
- without a load, the position moves by at most one per cycle;
- without an SCL rising edge, the position does not move.

The bench scenarios are needed for the rest:
- the reset value;
- the step direction;
- saturation at each end;
- step mode persisting across many pulses and ending at a stop;
- a held-high SCL giving a single step.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
  localparam int unsigned POS_W_DEF = 6;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/wcr_bus_edge.sv
module wcr_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  // Previous samples; the bus idles high, so that is the reset state.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // R5/R11: one rising edge per SCL high pulse.
  assign scl_rise = scl_s & ~scl_q;
  // R9: SDA rising while SCL stays high.
  assign stop_det = scl_s & scl_q & sda_s & ~sda_q;
endmodule

// File: rtl/wcr_step_ctrl.sv
module wcr_step_ctrl
  import wcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_arm,
  input  logic  stop_det,
  input  logic  scl_rise,
  input  logic  sda_s,
  output step_e step_cmd
);
  logic mode_q;

  // R9: arm sets the mode, stop clears it, and arm wins a tie.
  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (step_arm) mode_q <= 1'b1;
    else if (stop_det) mode_q <= 1'b0;
  end

  // R5/R6/R8: the direction comes from SDA at the SCL rising edge.
  always_comb begin
    step_cmd = STEP_NONE;
    if (mode_q && scl_rise) step_cmd = sda_s ? STEP_UP : STEP_DN;
  end
endmodule

// File: rtl/wcr_pos_reg.sv
module wcr_pos_reg
  import wcr_pkg::*;
#(
  parameter int unsigned POS_W = POS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] dr0_val,
  input  logic             wr_valid,
  input  logic [POS_W-1:0] wr_data,
  input  logic             xfr_valid,
  input  logic [POS_W-1:0] xfr_data,
  input  step_e            step_cmd,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;
  localparam logic [POS_W-1:0] ONE     = POS_W'(1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_n;

  always_comb begin
    pos_n = pos_q;
    if (wr_valid)       pos_n = wr_data;   // R3, R10: host write first
    else if (xfr_valid) pos_n = xfr_data;  // R4
    else begin
      unique case (step_cmd)
        STEP_UP: if (pos_q != POS_MAX) pos_n = pos_q + ONE;  // R5, R7
        STEP_DN: if (pos_q != POS_MIN) pos_n = pos_q - ONE;  // R6, R7
        default: pos_n = pos_q;
      endcase
    end
  end

  // R2: reset recalls the default data register.
  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= dr0_val;
    else        pos_q <= pos_n;
  end

  assign pos = pos_q;
endmodule

// File: rtl/wcr_tap_decode.sv
module wcr_tap_decode #(
  parameter int unsigned POS_W = 6,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  // R1: one comparator per tap switch.
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap[g] = (pos == POS_W'(g));
  end
endmodule

// File: rtl/wcr_stepper.sv
module wcr_stepper
  import wcr_pkg::*;
#(
  parameter int unsigned POS_W = POS_W_DEF,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] dr0_val,
  input  logic             wr_valid,
  input  logic [POS_W-1:0] wr_data,
  input  logic             xfr_valid,
  input  logic [POS_W-1:0] xfr_data,
  input  logic             step_arm,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  logic  scl_rise;
  logic  stop_det;
  step_e step_cmd;

  wcr_bus_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .stop_det (stop_det)
  );

  wcr_step_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_arm (step_arm),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .sda_s    (sda_s),
    .step_cmd (step_cmd)
  );

  wcr_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .dr0_val   (dr0_val),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .xfr_valid (xfr_valid),
    .xfr_data  (xfr_data),
    .step_cmd  (step_cmd),
    .pos       (pos)
  );

  wcr_tap_decode #(.POS_W(POS_W)) u_dec (
    .pos (pos),
    .tap (tap)
  );
endmodule

// File: rtl/wcr_stepper_chk.sv
module wcr_stepper_chk #(
  parameter int unsigned POS_W = 6,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [POS_W-1:0] wr_data,
  input logic             xfr_valid,
  input logic [POS_W-1:0] xfr_data,
  input logic             scl_s,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap
);
  assert_tap_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap) == 1) && tap[pos]);

  assert_host_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (pos == $past(wr_data)));

  assert_copy_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_valid && !wr_valid) |=> (pos == $past(xfr_data)));

  // R5/R6/R7: without a load the position moves by at most one.
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !xfr_valid) |=>
      ((pos == $past(pos)) || (pos == $past(pos) + POS_W'(1)) ||
       (pos == $past(pos) - POS_W'(1))));

  // R8/R11: no SCL rising edge and no load means the position holds.
  assert_hold_no_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !xfr_valid && !(scl_s && !$past(scl_s))) |=> $stable(pos));
endmodule

bind wcr_stepper wcr_stepper_chk #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .xfr_valid (xfr_valid),
  .xfr_data  (xfr_data),
  .scl_s     (scl_s),
  .pos       (pos),
  .tap       (tap)
);

// File: tb/wcr_stepper_tb_top.sv
module wcr_stepper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] dr0_val = 6'h15;
  logic       wr_valid = 1'b0;
  logic [5:0] wr_data = '0;
  logic       xfr_valid = 1'b0;
  logic [5:0] xfr_data = '0;
  logic       step_arm = 1'b0;
  logic       scl_s = 1'b1;
  logic       sda_s = 1'b1;
  logic [5:0] pos;
  logic [63:0] tap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state kept by the bench
  logic [5:0] m_pos;
  bit m_mode, m_scl, m_sda;
  string m_tag;

  always #2 clk = ~clk;  // 250 MHz

  wcr_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .dr0_val(dr0_val),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .xfr_valid(xfr_valid), .xfr_data(xfr_data),
    .step_arm(step_arm), .scl_s(scl_s), .sda_s(sda_s),
    .pos(pos), .tap(tap)
  );

  function automatic logic [63:0] exp_tap(input logic [5:0] p);
    return 64'd1 << p;
  endfunction

  // Apply the requirements to one clock edge with the current inputs.
  task automatic model_edge();
    bit rise, stop;
    if (!rst_n) begin
      m_pos = dr0_val; m_mode = 0; m_scl = 1; m_sda = 1; m_tag = "R2";
      return;
    end
    rise = scl_s && !m_scl;
    stop = scl_s && m_scl && sda_s && !m_sda;
    m_tag = "R8";
    if (wr_valid) begin m_pos = wr_data; m_tag = "R3"; end
    else if (xfr_valid) begin m_pos = xfr_data; m_tag = "R4"; end
    else if (m_mode && rise) begin
      if (sda_s) begin m_tag = "R5"; if (m_pos != 6'h3F) m_pos++; else m_tag = "R7"; end
      else begin m_tag = "R6"; if (m_pos != 6'h00) m_pos--; else m_tag = "R7"; end
    end
    if (step_arm) m_mode = 1;
    else if (stop) begin m_mode = 0; m_tag = "R9"; end
    m_scl = scl_s; m_sda = sda_s;
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (pos !== m_pos) begin
      n_bad++;
      $display("FAIL %s pos actual=%h expected=%h", tag, pos, m_pos);
    end
    n_chk++;
    if (tap !== exp_tap(m_pos)) begin
      n_bad++;
      $display("FAIL R1 tap actual=%h expected=%h", tap, exp_tap(m_pos));
    end
  endtask

  // Drive one cycle at the negative edge, update the model, sample at the next negative edge.
  task automatic cyc(input bit wv, input logic [5:0] wd, input bit xv, input logic [5:0] xd,
                     input bit arm, input bit scl, input bit sda, input string tag = "");
    wr_valid = wv; wr_data = wd; xfr_valid = xv; xfr_data = xd;
    step_arm = arm; scl_s = scl; sda_s = sda;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag == "" ? m_tag : tag);
  endtask

  task automatic idle(input string tag = ""); cyc(0, 0, 0, 0, 0, 0, sda_s, tag); endtask
  task automatic pulse(input bit dir, input string tag = "");
    cyc(0, 0, 0, 0, 0, 0, dir, tag);
    cyc(0, 0, 0, 0, 0, 1, dir, tag);
    cyc(0, 0, 0, 0, 0, 0, dir, tag);
  endtask
  task automatic stop_cond();
    cyc(0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0408));
    @(negedge clk);
    // R2: reset recalls the default register value
    rst_n = 0;
    cyc(0, 0, 0, 0, 0, 1, 1, "R2");
    cyc(0, 0, 0, 0, 0, 1, 1, "R2");
    rst_n = 1;
    idle("R2");
    // R8: pulses without step mode do nothing
    pulse(1, "R8"); pulse(0, "R8");
    // R3 host write, R4 copy, R4 both-valid priority
    cyc(1, 6'h2A, 0, 0, 0, 0, 1, "R3");
    cyc(0, 0, 1, 6'h3E, 0, 0, 1, "R4");
    cyc(1, 6'h11, 1, 6'h22, 0, 0, 1, "R4");
    cyc(1, 6'h3E, 0, 0, 0, 0, 1, "R3");
    // R9 arm, R5 up then R7 saturate at 3F
    cyc(0, 0, 0, 0, 1, 0, 1, "R9");
    pulse(1, "R5"); pulse(1, "R7"); pulse(1, "R7");
    // R11: SCL held high for several cycles gives one step
    cyc(0, 0, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, 0, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, "R11");
    // R6 down, R7 saturate at 00
    cyc(1, 6'h01, 0, 0, 0, 0, 0, "R3");
    pulse(0, "R6"); pulse(0, "R7"); pulse(0, "R7");
    // R10: load at the same edge as an SCL rise
    cyc(0, 0, 0, 0, 0, 0, 1, "R10");
    cyc(0, 0, 1, 6'h30, 0, 1, 1, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, "R10");
    // R9: stop ends step mode; later pulses are ignored
    stop_cond();
    pulse(1, "R9"); pulse(0, "R9");
    // R9: arm and stop at the same edge, arm wins
    cyc(0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 1, 1, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9");
    pulse(1, "R9");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 4, 6'($urandom), (r >= 4 && r < 8) || r == 99, 6'($urandom),
          (r >= 8 && r < 12), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule